// File: doc/BRIEF.md
# User-Level Notification Router

This block carries notifications between user threads without carrying any data. A sender names a slot of a sender-side routing table. The slot names a receiver and a vector number. The block records the vector as pending in that receiver's descriptor. If the receiver has no notification already in flight and is not suppressed, the block marks one as outstanding. The receiver's scheduling state then decides what happens next. A running receiver is interrupted directly. A descheduled receiver keeps its pending state until it runs again. A blocked receiver raises a wake request to the kernel.

Each receiver has its own interrupt-enable flag, which gates delivery. The flag can be cleared, set and tested through a small operation port, and a handler-return operation sets it again. One delivery is made per cycle. The lowest-numbered ready receiver goes first, and within it the lowest-numbered pending vector is presented. The routing table and the suppress bits are loaded through write ports. All of this state sits in on-chip registers.

Top module: `unotify_ctrl`

## Requirements
- R1: After reset, every flag, pending bit, outstanding bit and suppress bit is 0, every table slot is invalid, and the `dlv_vld`, `wake_vld`, `fault` and `test_val` outputs are 0.
- R2: A send to a valid slot holding receiver r and vector v sets `pend` bit r*NVEC+v at the clock edge that samples the send.
- R3: A send marks receiver r outstanding only when r was not outstanding and r's suppress bit is 0. Under suppression the pending bit is still set, but neither a delivery nor a wake follows.
- R4: A running receiver (state code 2'b00) whose flag is 1 and which is outstanding is delivered at the next edge. `dlv_vld` pulses with `dlv_rcv`=r and `dlv_vec` set to the lowest pending vector. At the same edge the flag, the outstanding bit and that pending bit are cleared.
- R5: While a receiver's flag is 0, no delivery is made to it. Delivery happens on the edge after the flag is set again.
- R6: A descheduled receiver (2'b01, and the unused code 2'b11) keeps its outstanding and pending state and receives nothing. It is delivered on the first edge at which its state reads running.
- R7: A send that newly marks a blocked receiver (2'b10) outstanding pulses `wake_vld` with `wake_rcv`=r on the same edge. No delivery is made to it while it is blocked.
- R8: A send to a slot marked invalid sets no pending bit and pulses `fault` for one cycle.
- R9: Operation codes on `op_code` for receiver `op_rcv`: 2'b00 clears the flag, 2'b01 sets it, 2'b10 loads the flag's current value into `test_val` on the next edge, and 2'b11 (handler return) sets the flag.
- R10: A send to a receiver that is already outstanding produces no further wake or delivery event.
- R11: When several receivers are ready at once, one is delivered per cycle, lowest receiver index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Write one routing-table slot |
| tbl_idx | input | 3 | Slot to write |
| tbl_ok | input | 1 | Valid bit written to the slot |
| tbl_rcv | input | 2 | Receiver written to the slot |
| tbl_vec | input | 3 | Vector written to the slot |
| sup_we | input | 1 | Write one receiver's suppress bit |
| sup_rcv | input | 2 | Receiver whose suppress bit is written |
| sup_val | input | 1 | Suppress value |
| send_en | input | 1 | Issue a notification |
| send_idx | input | 3 | Routing-table slot used by the send |
| rcv_state | input | 8 | 2 bits per receiver: 00 running, 01 descheduled, 10 blocked |
| op_en | input | 1 | Flag operation strobe |
| op_rcv | input | 2 | Receiver addressed by the operation |
| op_code | input | 2 | 00 clear, 01 set, 10 test, 11 handler return |
| dlv_vld | output | 1 | Direct delivery pulse |
| dlv_rcv | output | 2 | Receiver interrupted |
| dlv_vec | output | 3 | Vector presented |
| wake_vld | output | 1 | Kernel wake pulse for a blocked receiver |
| wake_rcv | output | 2 | Receiver to wake |
| fault | output | 1 | Send hit an invalid slot |
| test_val | output | 1 | Flag value captured by a test operation |
| uif | output | 4 | Interrupt-enable flag per receiver |
| pend | output | 32 | Pending vector bits, receiver-major |
| outstanding | output | 4 | Outstanding-notification bit per receiver |

## Verification
The bench covers sends that arrive while a receiver is masked, suppressed, descheduled or blocked, and repeated sends while one is already outstanding. A design that ignores the flag would interrupt early. One that ignores suppression or re-arms on every send would emit extra deliveries or kernel wakes. One that drops pending state for descheduled receivers would never deliver once the thread runs. Vector priority is tested with a vector posted under suppression: a later higher vector must not overtake it. Receiver priority is tested by releasing two receivers in the same cycle. Invalid slots must fault without leaving any pending bit behind.

// File: rtl/unotify_ctrl.sv
module unotify_ctrl #(
  parameter int NRCV = 4,
  parameter int NTAB = 8,
  parameter int NVEC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_we,
  input  logic [$clog2(NTAB)-1:0]  tbl_idx,
  input  logic                     tbl_ok,
  input  logic [$clog2(NRCV)-1:0]  tbl_rcv,
  input  logic [$clog2(NVEC)-1:0]  tbl_vec,
  input  logic                     sup_we,
  input  logic [$clog2(NRCV)-1:0]  sup_rcv,
  input  logic                     sup_val,
  input  logic                     send_en,
  input  logic [$clog2(NTAB)-1:0]  send_idx,
  input  logic [2*NRCV-1:0]        rcv_state,
  input  logic                     op_en,
  input  logic [$clog2(NRCV)-1:0]  op_rcv,
  input  logic [1:0]               op_code,
  output logic                     dlv_vld,
  output logic [$clog2(NRCV)-1:0]  dlv_rcv,
  output logic [$clog2(NVEC)-1:0]  dlv_vec,
  output logic                     wake_vld,
  output logic [$clog2(NRCV)-1:0]  wake_rcv,
  output logic                     fault,
  output logic                     test_val,
  output logic [NRCV-1:0]          uif,
  output logic [NRCV*NVEC-1:0]     pend,
  output logic [NRCV-1:0]          outstanding
);
  localparam int RW = $clog2(NRCV);
  localparam int VW = $clog2(NVEC);
  localparam int PW = NRCV * NVEC;
  localparam logic [1:0] ST_RUN = 2'b00;
  localparam logic [1:0] ST_BLK = 2'b10;
  localparam logic [1:0] OP_CLR = 2'b00;
  localparam logic [1:0] OP_SET = 2'b01;
  localparam logic [1:0] OP_TST = 2'b10;
  localparam logic [1:0] OP_RET = 2'b11;

  logic          slot_ok  [NTAB];
  logic [RW-1:0] slot_rcv [NTAB];
  logic [VW-1:0] slot_vec [NTAB];

  logic [PW-1:0]   pend_q;
  logic [NRCV-1:0] on_q, sup_q, flag_q;

  wire          hit_ok  = slot_ok[send_idx];
  wire [RW-1:0] hit_rcv = slot_rcv[send_idx];
  wire [VW-1:0] hit_vec = slot_vec[send_idx];
  wire          post    = send_en & hit_ok;
  wire          arm     = post & ~on_q[hit_rcv] & ~sup_q[hit_rcv];
  wire [1:0]    hit_st  = rcv_state[2*hit_rcv +: 2];

  logic [NRCV-1:0] ready;
  logic            go;
  logic [RW-1:0]   go_rcv;
  logic [VW-1:0]   go_vec;
  logic [NVEC-1:0] go_slice;

  always_comb begin
    for (int r = 0; r < NRCV; r++)
      ready[r] = on_q[r] & flag_q[r] & (rcv_state[2*r +: 2] == ST_RUN)
               & (|pend_q[r*NVEC +: NVEC]);
    go = |ready;
    go_rcv = '0;
    for (int r = NRCV-1; r >= 0; r--)
      if (ready[r]) go_rcv = RW'(r);
    go_slice = pend_q[go_rcv*NVEC +: NVEC];
    go_vec = '0;
    for (int v = NVEC-1; v >= 0; v--)
      if (go_slice[v]) go_vec = VW'(v);
  end

  logic [PW-1:0]   pend_n;
  logic [NRCV-1:0] on_n, flag_n;

  always_comb begin
    pend_n = pend_q;
    if (go)   pend_n[go_rcv*NVEC + int'(go_vec)] = 1'b0;
    if (post) pend_n[hit_rcv*NVEC + int'(hit_vec)] = 1'b1;
    on_n = on_q;
    if (go)  on_n[go_rcv] = 1'b0;
    if (arm) on_n[hit_rcv] = 1'b1;
    flag_n = flag_q;
    if (op_en && op_code == OP_CLR) flag_n[op_rcv] = 1'b0;
    if (op_en && (op_code == OP_SET || op_code == OP_RET)) flag_n[op_rcv] = 1'b1;
    if (go) flag_n[go_rcv] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTAB; t++) begin
        slot_ok[t]  <= 1'b0;
        slot_rcv[t] <= '0;
        slot_vec[t] <= '0;
      end
    end else if (tbl_we) begin
      slot_ok[tbl_idx]  <= tbl_ok;
      slot_rcv[tbl_idx] <= tbl_rcv;
      slot_vec[tbl_idx] <= tbl_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      on_q     <= '0;
      sup_q    <= '0;
      flag_q   <= '0;
      dlv_vld  <= 1'b0;
      dlv_rcv  <= '0;
      dlv_vec  <= '0;
      wake_vld <= 1'b0;
      wake_rcv <= '0;
      fault    <= 1'b0;
      test_val <= 1'b0;
    end else begin
      pend_q   <= pend_n;
      on_q     <= on_n;
      flag_q   <= flag_n;
      if (sup_we) sup_q[sup_rcv] <= sup_val;
      dlv_vld  <= go;
      dlv_rcv  <= go_rcv;
      dlv_vec  <= go_vec;
      wake_vld <= arm & (hit_st == ST_BLK);
      wake_rcv <= hit_rcv;
      fault    <= send_en & ~hit_ok;
      if (op_en && op_code == OP_TST) test_val <= flag_q[op_rcv];
    end
  end

  assign uif         = flag_q;
  assign pend        = pend_q;
  assign outstanding = on_q;
endmodule

// File: rtl/unotify_ctrl_chk.sv
module unotify_ctrl_chk #(
  parameter int NRCV = 4,
  parameter int NVEC = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dlv_vld,
  input logic [$clog2(NRCV)-1:0] dlv_rcv,
  input logic [$clog2(NVEC)-1:0] dlv_vec,
  input logic                    wake_vld,
  input logic [$clog2(NRCV)-1:0] wake_rcv,
  input logic                    fault,
  input logic [NRCV-1:0]         uif,
  input logic [NRCV*NVEC-1:0]    pend,
  input logic [NRCV-1:0]         outstanding
);
  logic [NRCV*NVEC-1:0] pend_d;
  always_ff @(posedge clk) begin
    if (!rst_n) pend_d <= '0;
    else        pend_d <= pend;
  end
  wire was_pending = pend_d[int'(dlv_rcv)*NVEC + int'(dlv_vec)];

  a_r4_flag_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_vld |-> !uif[dlv_rcv] && !outstanding[dlv_rcv]);
  a_r4_vec_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_vld |-> was_pending);
  a_r8_fault_posts_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ((pend & ~$past(pend)) == '0));
  a_r7_wake_not_delivered: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vld && dlv_vld) |-> (wake_rcv != dlv_rcv));
  a_r3_wake_is_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    wake_vld |-> outstanding[wake_rcv]);
endmodule

bind unotify_ctrl unotify_ctrl_chk #(.NRCV(NRCV), .NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dlv_vld(dlv_vld), .dlv_rcv(dlv_rcv),
  .dlv_vec(dlv_vec), .wake_vld(wake_vld), .wake_rcv(wake_rcv),
  .fault(fault), .uif(uif), .pend(pend), .outstanding(outstanding));

// File: tb/unotify_ctrl_test.sv
`timescale 1ns/1ps
module unotify_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic tbl_we = 0, tbl_ok = 0, sup_we = 0, sup_val = 0, send_en = 0, op_en = 0;
  logic [2:0] tbl_idx = 0, tbl_vec = 0, send_idx = 0;
  logic [1:0] tbl_rcv = 0, sup_rcv = 0, op_rcv = 0, op_code = 0;
  logic [7:0] rs = 8'h00;
  logic dlv_vld, wake_vld, fault, test_val;
  logic [1:0] dlv_rcv, wake_rcv;
  logic [2:0] dlv_vec;
  logic [3:0] uif, outstanding;
  logic [31:0] pend, pend_snap;

  unotify_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_ok(tbl_ok),
    .tbl_rcv(tbl_rcv), .tbl_vec(tbl_vec), .sup_we(sup_we), .sup_rcv(sup_rcv),
    .sup_val(sup_val), .send_en(send_en), .send_idx(send_idx), .rcv_state(rs),
    .op_en(op_en), .op_rcv(op_rcv), .op_code(op_code), .dlv_vld(dlv_vld),
    .dlv_rcv(dlv_rcv), .dlv_vec(dlv_vec), .wake_vld(wake_vld), .wake_rcv(wake_rcv),
    .fault(fault), .test_val(test_val), .uif(uif), .pend(pend),
    .outstanding(outstanding));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    tbl_we = 0; sup_we = 0; op_en = 0;
  endtask

  task automatic wr_slot(int s, logic ok, logic [1:0] r, logic [2:0] v);
    tbl_we = 1; tbl_idx = 3'(s); tbl_ok = ok; tbl_rcv = r; tbl_vec = v; cyc();
  endtask

  task automatic op(logic [1:0] r, logic [1:0] c);
    op_en = 1; op_rcv = r; op_code = c; cyc();
  endtask

  task automatic send(int s);
    send_en = 1; send_idx = 3'(s); cyc(); send_en = 0;
  endtask

  // {receiver[1:0], vector[2:0], state[1:0]}
  localparam logic [6:0] VT [7] = '{
    {2'd0, 3'd3, 2'b00}, {2'd1, 3'd0, 2'b01}, {2'd2, 3'd7, 2'b10},
    {2'd3, 3'd5, 2'b00}, {2'd0, 3'd6, 2'b10}, {2'd1, 3'd2, 2'b00},
    {2'd3, 3'd1, 2'b01}};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    chk("R1 uif", uif, 0);
    chk("R1 pend", pend, 0);
    chk("R1 outstanding", outstanding, 0);
    chk("R1 outputs", {dlv_vld, wake_vld, fault, test_val}, 0);

    for (int i = 0; i < 7; i++) begin
      logic [1:0] vr; logic [2:0] vv; logic [1:0] vs;
      {vr, vv, vs} = VT[i];
      tbl_we = 1; tbl_idx = 3'(i); tbl_ok = 1; tbl_rcv = vr; tbl_vec = vv;
      op_en = 1; op_rcv = vr; op_code = 2'b01;
      rs = 8'h55; rs[vr*2 +: 2] = vs;
      cyc();
      send(i);
      chk("R2 pend bit set", pend[vr*8+vv], 1);
      chk("R3 outstanding", outstanding[vr], 1);
      chk("R7 wake", wake_vld, 32'(vs == 2'b10));
      if (vs == 2'b10) chk("R7 wake_rcv", wake_rcv, vr);
      cyc();
      chk("R4/R6/R7 direct delivery", dlv_vld, 32'(vs == 2'b00));
      if (vs != 2'b00) begin
        rs[vr*2 +: 2] = 2'b00;
        cyc();
        chk("R6 deliver on resume", dlv_vld, 1);
      end
      chk("R4 rcv", dlv_rcv, vr);
      chk("R4 vec", dlv_vec, vv);
      chk("R4 flag cleared", uif[vr], 0);
      chk("R4 pend cleared", pend[vr*8+vv], 0);
      op(vr, 2'b11);
      chk("R9 return sets flag", uif[vr], 1);
    end

    rs = 8'h00;
    op(2'd1, 2'b00);
    wr_slot(0, 1, 2'd1, 3'd4);
    send(0);
    cyc();
    chk("R5 masked no delivery", dlv_vld, 0);
    chk("R5 outstanding kept", outstanding[1], 1);
    op(2'd1, 2'b10);
    chk("R9 test reads 0", test_val, 0);
    op(2'd1, 2'b01);
    cyc();
    chk("R5 delivery after unmask", {dlv_vld, dlv_rcv, dlv_vec}, {1'b1, 2'd1, 3'd4});
    op(2'd1, 2'b10);
    chk("R9 test after delivery", test_val, 0);
    op(2'd1, 2'b11);
    op(2'd1, 2'b10);
    chk("R9 test after return", test_val, 1);

    pend_snap = pend;
    send(7);
    chk("R8 fault", fault, 1);
    chk("R8 pend untouched", pend, pend_snap);
    cyc();
    chk("R8 fault is a pulse", fault, 0);

    sup_we = 1; sup_rcv = 2'd2; sup_val = 1; cyc();
    wr_slot(1, 1, 2'd2, 3'd5);
    wr_slot(2, 1, 2'd2, 3'd6);
    send(1);
    chk("R3 suppressed pend", pend[21], 1);
    chk("R3 suppressed not outstanding", outstanding[2], 0);
    cyc();
    chk("R3 suppressed no delivery", dlv_vld, 0);
    sup_we = 1; sup_val = 0; cyc();
    send(2);
    chk("R3 outstanding after unsuppress", outstanding[2], 1);
    cyc();
    chk("R4 lowest vector first", {dlv_vld, dlv_rcv, dlv_vec}, {1'b1, 2'd2, 3'd5});
    chk("R4 higher vector stays pending", pend[22], 1);
    op(2'd2, 2'b11);

    rs[7:6] = 2'b10;
    wr_slot(3, 1, 2'd3, 3'd2);
    send_en = 1; send_idx = 3'd3; cyc();
    chk("R7 first wake", wake_vld, 1);
    cyc(); send_en = 0;
    chk("R10 no second wake", wake_vld, 0);
    chk("R7 no delivery while blocked", dlv_vld, 0);
    rs[7:6] = 2'b00;
    cyc();
    chk("R6 blocked then running", {dlv_vld, dlv_rcv, dlv_vec}, {1'b1, 2'd3, 3'd2});
    cyc();
    chk("R10 single delivery", dlv_vld, 0);
    op(2'd3, 2'b11);

    rs = 8'h55;
    wr_slot(4, 1, 2'd0, 3'd1);
    wr_slot(5, 1, 2'd1, 3'd0);
    send(4);
    send(5);
    chk("R6 both outstanding", outstanding[1:0], 2'b11);
    rs = 8'h00;
    cyc();
    chk("R11 receiver 0 first", {dlv_vld, dlv_rcv, dlv_vec}, {1'b1, 2'd0, 3'd1});
    cyc();
    chk("R11 receiver 1 next", {dlv_vld, dlv_rcv, dlv_vec}, {1'b1, 2'd1, 3'd0});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule